// File: doc/BRIEF.md
# Audio Transmit Queue Controller

This block is the register-mapped front end of an audio transmitter. A host writes configuration, interrupt mask and sample words over a simple word-addressed register bus. Sample words go into a deep transmit queue, one 32-bit word per channel. Each frame is two words, left first and then right, and both are written to the same data port. On the other side, a serializer takes whole stereo pairs through a valid/ready handshake and reads its clock ratio, resolution, channel and enable settings from the configuration fields.

The block reports two live conditions: the queue is empty, and the queue occupancy is below a low-water mark. The low-water mark is the queue depth shifted right by a 4-bit level field. Each condition can be masked. A single interrupt line is raised when the global interrupt enable is set and an unmasked condition holds. Both conditions clear themselves when the occupancy changes, so there is nothing to acknowledge. When the host writes a sample while the queue is full, the bus is held off until a pair drains, and the sample is not dropped.

Top module: `snd_txq_ctrl`

## Requirements
- R1: After reset the configuration and mask registers read 0, the queue is empty, the status register reads 0x3, irq is low and pair_valid is low.
- R2: Word index 0 reads the VERSION parameter. Writes to it have no effect.
- R3: Word index 1 is the configuration register. Only bits 0 (transmit enable), 1 (interrupt enable), 2 (left flag), 15:8 (clock ratio), 21:16 (resolution), 27:24 (level select) and 31:28 (channel) hold data, so the readback mask is 0xFF3FFF07. The ser_* outputs follow the matching fields.
- R4: Word index 2 is the mask register, and only bits 1:0 are kept. Word index 3 is the status register: bit 0 is 1 while the queue is empty, and bit 1 is 1 while occupancy is below the low-water mark. Writing the status register has no effect.
- R5: The low-water mark equals DEPTH shifted right by the level-select field. A field of 0 gives DEPTH, and each step halves the mark.
- R6: A write to word index 4 appends the write data to the queue. Reads of word indices 4 to 7 return 0. Writes to indices 5 to 7 leave the queue unchanged.
- R7: A write to index 4 while the queue holds DEPTH words keeps bus_rdy low until a pair is popped. The word is then stored, and the queue never exceeds DEPTH words.
- R8: pair_valid is high only while at least two words are queued. pair_left is the oldest word and pair_right is the next one. A cycle with pair_valid and pair_ready high removes both words.
- R9: irq is high exactly when the interrupt enable bit is set and (status AND mask) is nonzero.
- R10: bus_rdy is high for every request except the stalled write of R7. Read data appears on bus_rdata in the cycle after the read is accepted, and it holds until the next read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdy | output | 1 | Request accepted at this edge when high |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| pair_valid | output | 1 | A stereo pair is available |
| pair_ready | input | 1 | Serializer takes the pair |
| pair_left | output | 32 | Left word of the pair |
| pair_right | output | 32 | Right word of the pair |
| ser_enable | output | 1 | Transmit enable field |
| ser_left | output | 1 | Left flag field |
| ser_ratio | output | 8 | Clock ratio field |
| ser_res | output | 6 | Sample resolution field |
| ser_chan | output | 4 | Channel field |

## Verification
Writes take effect at the edge that accepts them. Status bits, irq, pair_valid and the ser_* fields are combinational from registers, so the bench samples them at the falling edge that follows the accepting edge. A read returns the state as it stood at its accepting edge and is sampled at the next falling edge. A scoreboard records each data word at the edge that accepts it. A monitor checks every popped pair one time unit after the falling edge, before the edge that removes the pair. This lets the bench compare exact cycles even during the stall, when acceptance is deferred by a variable number of cycles.

// File: rtl/snd_txq_pkg.sv
package snd_txq_pkg;

   typedef enum logic [2:0] {
      RI_VER  = 3'd0,
      RI_CFG  = 3'd1,
      RI_MASK = 3'd2,
      RI_STAT = 3'd3,
      RI_D0   = 3'd4,
      RI_D1   = 3'd5,
      RI_D2   = 3'd6,
      RI_D3   = 3'd7
   } txq_reg_e;

   // configuration fields held in flops (reserved bits are not stored)
   typedef struct packed {
      logic [3:0] chan;
      logic [3:0] lvl;
      logic [5:0] res;
      logic [7:0] ratio;
      logic       left;
      logic       ie;
      logic       en;
   } txq_cfg_t;

   localparam int unsigned STAT_W = 2;

   function automatic logic [31:0] cfg_to_word(input txq_cfg_t c);
      return {c.chan, c.lvl, 2'b00, c.res, c.ratio, 5'b00000, c.left, c.ie, c.en};
   endfunction

endpackage

// File: rtl/snd_txq_regs.sv
module snd_txq_regs
   import snd_txq_pkg::*;
#(
   parameter logic [31:0] VERSION = 32'h5A01_0003
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_wr,
   input  logic [2:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic                bus_rdy,
   output logic [31:0]         bus_rdata,
   input  logic                fifo_full,
   input  logic [STAT_W-1:0]   status,
   output logic                push_valid,
   output logic [31:0]         push_data,
   output txq_cfg_t            cfg,
   output logic [STAT_W-1:0]   mask
);

   txq_reg_e    idx;
   logic        hit_data;
   logic        accept;
   txq_cfg_t    cfg_q;
   logic [STAT_W-1:0] mask_q;
   logic [31:0] rd_mux;
   logic [31:0] rdata_q;

   assign idx      = txq_reg_e'(bus_addr);
   assign hit_data = bus_req && bus_wr && (idx == RI_D0);
   assign bus_rdy  = !(hit_data && fifo_full);
   assign accept   = bus_req && bus_rdy;

   assign push_valid = hit_data && !fifo_full;
   assign push_data  = bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '0;
      end else if (accept && bus_wr) begin
         case (idx)
            RI_CFG: begin
               cfg_q.en    <= bus_wdata[0];
               cfg_q.ie    <= bus_wdata[1];
               cfg_q.left  <= bus_wdata[2];
               cfg_q.ratio <= bus_wdata[15:8];
               cfg_q.res   <= bus_wdata[21:16];
               cfg_q.lvl   <= bus_wdata[27:24];
               cfg_q.chan  <= bus_wdata[31:28];
            end
            RI_MASK: mask_q <= bus_wdata[STAT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         RI_VER:  rd_mux = VERSION;
         RI_CFG:  rd_mux = cfg_to_word(cfg_q);
         RI_MASK: rd_mux = {{(32-STAT_W){1'b0}}, mask_q};
         RI_STAT: rd_mux = {{(32-STAT_W){1'b0}}, status};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rdata_q <= '0;
      else if (accept && !bus_wr) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign cfg       = cfg_q;
   assign mask      = mask_q;

   a_r2_version_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && bus_addr == 3'd0) |=> (bus_rdata == VERSION));

   a_r4_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == 3'd3) |=> ($stable(cfg_q) && $stable(mask_q)));

   a_r10_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_wr) |=> $stable(bus_rdata));

endmodule

// File: rtl/snd_txq_store.sv
module snd_txq_store #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = AW + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [WORD_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [CW-1:0]     count_o,
   output logic              full_o,
   output logic              pair_valid_o,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o
);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [CW-1:0]     count;
   logic              pop_ok;

   assign pair_valid_o = (count >= CW'(2));
   assign full_o       = (count == CW'(DEPTH));
   assign pop_ok       = pop_i && pair_valid_o;

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_ptr] <= push_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok) rd_ptr <= rd_ptr + AW'(2);
         count <= count + (push_i ? CW'(1) : CW'(0)) - (pop_ok ? CW'(2) : CW'(0));
      end
   end

   assign left_o  = mem[rd_ptr];
   assign right_o = mem[rd_ptr + AW'(1)];
   assign count_o = count;

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);

   a_r8_pop_drops_two: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && pair_valid_o && !push_i) |=> (count == $past(count) - CW'(2)));

   a_r8_refused_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_valid_o && !push_i) |=> $stable(count));

endmodule

// File: rtl/snd_txq_irq.sv
module snd_txq_irq
   import snd_txq_pkg::*;
#(
   parameter int unsigned DEPTH   = 512,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned CW     = $clog2(DEPTH) + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     count,
   input  logic [3:0]        lvl,
   input  logic              ie,
   input  logic [STAT_W-1:0] mask,
   output logic [STAT_W-1:0] status,
   output logic              irq
);

   logic [CW-1:0] low_mark;
   logic          irq_raw;

   assign low_mark  = CW'(DEPTH) >> lvl;
   assign status[0] = (count == '0);
   assign status[1] = (count < low_mark);
   assign irq_raw   = ie && |(status & mask);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
         a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ie);
      end
   endgenerate

   a_r4_empty_below_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && lvl < 4'(CW)) |-> status[1]);

endmodule

// File: rtl/snd_txq_ctrl.sv
module snd_txq_ctrl
   import snd_txq_pkg::*;
#(
   parameter int unsigned DEPTH   = 512,
   parameter logic [31:0] VERSION = 32'h5A01_0003,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned CW     = $clog2(DEPTH) + 1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_req,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic        bus_rdy,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        pair_valid,
   input  logic        pair_ready,
   output logic [31:0] pair_left,
   output logic [31:0] pair_right,
   output logic        ser_enable,
   output logic        ser_left,
   output logic [7:0]  ser_ratio,
   output logic [5:0]  ser_res,
   output logic [3:0]  ser_chan
);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("snd_txq_ctrl: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   txq_cfg_t          cfg;
   logic [STAT_W-1:0] mask;
   logic [STAT_W-1:0] status;
   logic              push_valid;
   logic [31:0]       push_data;
   logic              fifo_full;
   logic [CW-1:0]     count;

   snd_txq_regs #(.VERSION(VERSION)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_req    (bus_req),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdy    (bus_rdy),
      .bus_rdata  (bus_rdata),
      .fifo_full  (fifo_full),
      .status     (status),
      .push_valid (push_valid),
      .push_data  (push_data),
      .cfg        (cfg),
      .mask       (mask)
   );

   snd_txq_store #(.DEPTH(DEPTH), .WORD_W(32)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (push_valid),
      .push_data_i  (push_data),
      .pop_i        (pair_ready),
      .count_o      (count),
      .full_o       (fifo_full),
      .pair_valid_o (pair_valid),
      .left_o       (pair_left),
      .right_o      (pair_right)
   );

   snd_txq_irq #(.DEPTH(DEPTH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (count),
      .lvl    (cfg.lvl),
      .ie     (cfg.ie),
      .mask   (mask),
      .status (status),
      .irq    (irq)
   );

   assign ser_enable = cfg.en;
   assign ser_left   = cfg.left;
   assign ser_ratio  = cfg.ratio;
   assign ser_res    = cfg.res;
   assign ser_chan   = cfg.chan;

   a_r10_stall_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rdy) |-> (bus_wr && bus_addr == 3'd4));

   a_r8_valid_needs_words: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> !status[0]);

endmodule

// File: tb/test_snd_txq_ctrl.sv
module test_snd_txq_ctrl;

   localparam int unsigned DEPTH   = 512;
   localparam logic [31:0] VERSION = 32'h5A01_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rdy;
   logic [31:0] bus_rdata;
   logic        irq, pair_valid;
   logic        pair_ready = 1'b0;
   logic [31:0] pair_left, pair_right;
   logic        ser_enable, ser_left;
   logic [7:0]  ser_ratio;
   logic [5:0]  ser_res;
   logic [3:0]  ser_chan;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];

   always #2 clk = ~clk;

   snd_txq_ctrl #(.DEPTH(DEPTH), .VERSION(VERSION), .IRQ_REG(1'b0)) i_snd_txq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
      .bus_rdata(bus_rdata), .irq(irq), .pair_valid(pair_valid),
      .pair_ready(pair_ready), .pair_left(pair_left), .pair_right(pair_right),
      .ser_enable(ser_enable), .ser_left(ser_left), .ser_ratio(ser_ratio),
      .ser_res(ser_res), .ser_chan(ser_chan)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      while (!bus_rdy) begin @(negedge clk); #1; end
      @(posedge clk);
      if (a == 3'd4) exp_q.push_back(d);
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic drain();
      int guard = 0;
      @(negedge clk);
      pair_ready = 1'b1;
      while (exp_q.size() >= 2 && guard < 5000) begin @(negedge clk); guard++; end
      pair_ready = 1'b0;
   endtask

   // scoreboard monitor: compares each popped pair against the queue
   always @(negedge clk) begin
      #1;
      if (rst_n && pair_valid && pair_ready) begin
         if (exp_q.size() < 2) begin
            chk("R8 pop with fewer than two expected words", 32'(exp_q.size()), 32'd2);
         end else begin
            logic [31:0] l, r;
            l = exp_q.pop_front();
            r = exp_q.pop_front();
            chk("R8 pair_left", pair_left, l);
            chk("R8 pair_right", pair_right, r);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd1, v); chk("R1 cfg after reset", v, 32'h0);
      rd(3'd2, v); chk("R1 mask after reset", v, 32'h0);
      rd(3'd3, v); chk("R1 status after reset", v, 32'h3);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      chk("R1 pair_valid after reset", {31'b0, pair_valid}, 32'h0);

      // R2 version
      rd(3'd0, v); chk("R2 version", v, VERSION);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R2 version after write", v, VERSION);

      // R3 configuration fields
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v); chk("R3 cfg readback mask", v, 32'hFF3F_FF07);
      chk("R3 ser fields all ones", {13'b0, ser_chan, ser_res, ser_ratio, ser_left, ser_enable},
          {13'b0, 4'hF, 6'h3F, 8'hFF, 1'b1, 1'b1});
      wr(3'd1, 32'h1A15_0304);
      rd(3'd1, v); chk("R3 cfg pattern", v, 32'h1A15_0304);
      chk("R3 ser fields pattern", {13'b0, ser_chan, ser_res, ser_ratio, ser_left, ser_enable},
          {13'b0, 4'h1, 6'h15, 8'h03, 1'b1, 1'b0});
      wr(3'd1, 32'h0);

      // R4 mask and status
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v); chk("R4 mask readback", v, 32'h3);
      wr(3'd3, 32'h0);
      rd(3'd3, v); chk("R4 status write ignored", v, 32'h3);
      wr(3'd2, 32'h0);

      // R10 read data holds across writes and idle cycles
      wr(3'd1, 32'h0000_0304);
      rd(3'd1, v); chk("R10 read value", v, 32'h0000_0304);
      wr(3'd2, 32'h1);
      repeat (3) @(negedge clk);
      chk("R10 rdata holds", bus_rdata, 32'h0000_0304);
      wr(3'd2, 32'h0);
      wr(3'd1, 32'h0);

      // R6 data ports
      rd(3'd4, v); chk("R6 read index 4", v, 32'h0);
      rd(3'd7, v); chk("R6 read index 7", v, 32'h0);
      wr(3'd5, 32'hDEAD_BEEF);
      wr(3'd7, 32'hCAFE_F00D);
      rd(3'd3, v); chk("R6 side port writes ignored", v, 32'h3);
      chk("R6 pair_valid stays low", {31'b0, pair_valid}, 32'h0);

      // R5 low-water mark, level 8 -> mark 2
      wr(3'd1, 32'h0800_0000);
      rd(3'd3, v); chk("R5 empty at level 8", v, 32'h3);
      wr(3'd4, 32'h0000_0011);
      rd(3'd3, v); chk("R5 one word below mark 2", v, 32'h2);
      wr(3'd4, 32'h0000_0022);
      rd(3'd3, v); chk("R5 two words at mark 2", v, 32'h0);
      chk("R8 pair_valid with two words", {31'b0, pair_valid}, 32'h1);
      wr(3'd1, 32'h0900_0000);
      rd(3'd3, v); chk("R5 level 9 mark 1", v, 32'h0);
      wr(3'd1, 32'h0000_0000);
      rd(3'd3, v); chk("R5 level 0 mark DEPTH", v, 32'h2);

      // R9 interrupt combination
      wr(3'd1, 32'h0000_0002);
      wr(3'd2, 32'h3); chk("R9 irq level cause", {31'b0, irq}, 32'h1);
      wr(3'd2, 32'h1); chk("R9 irq empty masked-in but not empty", {31'b0, irq}, 32'h0);
      wr(3'd2, 32'h2); chk("R9 irq level only", {31'b0, irq}, 32'h1);
      wr(3'd1, 32'h0000_0000); chk("R9 irq disabled", {31'b0, irq}, 32'h0);
      wr(3'd1, 32'h0000_0002);
      drain();
      wr(3'd2, 32'h1); chk("R9 irq on empty", {31'b0, irq}, 32'h1);
      wr(3'd2, 32'h0); chk("R9 irq all masked", {31'b0, irq}, 32'h0);
      wr(3'd1, 32'h0);

      // R8 single word is not popped
      wr(3'd4, 32'h0000_0077);
      @(negedge clk); pair_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 refuse pop with one word", {31'b0, pair_valid}, 32'h0);
      pair_ready = 1'b0;
      rd(3'd3, v); chk("R8 single word kept", v, 32'h2);
      wr(3'd4, 32'h0000_0088);
      drain();

      // R8 streaming while the serializer pulls
      @(negedge clk); pair_ready = 1'b1;
      for (int i = 0; i < 40; i++) wr(3'd4, 32'h1000_0000 + 32'(i) * 32'h0001_0101);
      drain();
      rd(3'd3, v); chk("R8 empty after stream", v, 32'h3);

      // R7 full queue stalls the bus
      for (int i = 0; i < DEPTH; i++) wr(3'd4, 32'h2000_0000 + 32'(i));
      rd(3'd3, v); chk("R7 full status", v, 32'h0);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'hABCD_0123;
      #1; chk("R7 rdy low when full", {31'b0, bus_rdy}, 32'h0);
      repeat (2) @(negedge clk);
      #1; chk("R7 rdy still low", {31'b0, bus_rdy}, 32'h0);
      @(negedge clk);
      pair_ready = 1'b1;
      #1;
      while (!bus_rdy) begin @(negedge clk); #1; end
      chk("R10 rdy returns after pop", {31'b0, bus_rdy}, 32'h1);
      @(posedge clk);
      exp_q.push_back(32'hABCD_0123);
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
      wr(3'd4, 32'h0000_0055);
      drain();
      rd(3'd3, v); chk("R7 queue drained with stalled word", v, 32'h3);
      chk("R7 scoreboard empty", 32'(exp_q.size()), 32'd0);

      finish_run();
   end

endmodule